// File: doc/BRIEF.md
# Flash program and mass-erase strobe sequencer

This block drives the control strobes of a non-volatile memory array. For a byte-program operation it raises a program-mode strobe, then the high-voltage enable, then presents each data byte on a write strobe for a fixed step time, and finally releases the strobes in reverse order. For a mass erase it raises an erase-mode strobe, then high voltage, holds both for the erase time, drops the mode strobe and keeps high voltage on for a longer hold. Every sequence ends with a recovery gap with all strobes low before the block signals completion and accepts the next command.

All delays are given as parameters in nanoseconds together with a clock-frequency parameter in MHz. The block converts each delay to a whole number of clock cycles by rounding up. The block refuses a program request that would break a wear or stress rule, and reports the refusal with an error pulse. These rules are: crossing a row boundary, a third write to one byte since the last erase, or more cumulative high-voltage time on a row than its budget allows. An abort command ends any running sequence early without breaking the strobe ordering.

Top module: `flash_seq`

## Requirements
- R1: Each delay in cycles is ceil(delay_ns * CLK_MHZ / 1000), with a floor of one cycle. The delays are setup (T_SU), high voltage to first data (T_HVD), byte step (T_BYTE), program hold (T_HOLDP), erase time (T_ER), erase hold (T_HOLDE), recovery (T_REC) and row budget (BUDGET).
- R2: A program command (cmd_op = 1) accepted in idle raises pgm_mode and busy at the accepting edge. hv_en rises exactly T_SU cycles after pgm_mode.
- R3: arr_wr first rises no sooner than T_HVD cycles after hv_en. Each write step holds arr_wr high for exactly T_BYTE cycles, with pgm_mode and hv_en high throughout.
- R4: Bytes of one request go to consecutive addresses starting at cmd_addr and appear on arr_addr and arr_data. A byte is taken on a clock edge where din_valid is high while the block waits for data, and arr_wr rises at that same edge.
- R5: After the last write step, pgm_mode and arr_wr fall together. hv_en stays high exactly T_HOLDP cycles longer.
- R6: An erase command (cmd_op = 2) raises erase_mode, and hv_en T_SU cycles later. Both stay high for T_ER cycles. erase_mode then falls, and hv_en stays high for T_HOLDE more cycles.
- R7: After hv_en falls, all strobes stay low for T_REC cycles. After that, busy falls and done pulses for one cycle, and a command presented during that cycle is accepted.
- R8: Each cycle that hv_en is high during a program operation adds one to the budget accumulator of the request's row. A request is refused if the accumulator plus T_HVD + count*T_BYTE + T_HOLDP exceeds BUDGET.
- R9: A request that covers any byte already written twice since the last completed erase is refused.
- R10: A request with count 0, or with (cmd_addr mod ROW_BYTES) + count > ROW_BYTES, is refused. A refusal gives a one-cycle err pulse one cycle after the command, and busy and all strobes stay low.
- R11: While busy, program and erase commands are ignored.
- R12: An abort (cmd_op = 3) during a setup phase drops the mode strobe and goes straight to recovery. An abort during a high-voltage phase drops the mode strobe and arr_wr at once, then runs the normal hold for that operation and recovery.
- R13: A mass erase that completes without abort clears all write counts and budget accumulators. An aborted erase clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 1 program, 2 erase, 3 abort, 0 none |
| cmd_addr | input | ADDR_W | Start byte address of a program request |
| cmd_count | input | ROW_W+1 | Number of bytes to program |
| din | input | 8 | Next data byte |
| din_valid | input | 1 | din holds a byte ready to be taken |
| pgm_mode | output | 1 | Program-mode strobe |
| erase_mode | output | 1 | Mass-erase-mode strobe |
| hv_en | output | 1 | High-voltage enable strobe |
| arr_wr | output | 1 | Data write strobe |
| arr_addr | output | ADDR_W | Address of the byte being written |
| arr_data | output | 8 | Byte being written |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |

## Verification
A bad phase counter moves an edge of a strobe by one or more cycles. The cycle-by-cycle comparison shows this on the first cycle the edge is out of place. A wrong write-count or accumulator value stays hidden until a later request reaches the limit. At that point err appears where none was expected, or a sequence starts where err was expected, one cycle after the command. For this reason the stimulus drives the counts and budgets to exactly their limits, before and after both aborted and completed erases.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int     ADDR_W      = 6,
  parameter int     ROW_W       = 3,
  parameter longint CLK_MHZ     = 125,
  parameter longint T_SU_NS     = 5000,
  parameter longint T_HVD_NS    = 10000,
  parameter longint T_BYTE_NS   = 20000,
  parameter longint T_HOLDP_NS  = 5000,
  parameter longint T_ER_NS     = 500000000,
  parameter longint T_HOLDE_NS  = 100000,
  parameter longint T_REC_NS    = 1000,
  parameter longint BUDGET_NS   = 8000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ROW_W:0]    cmd_count,
  input  logic [7:0]        din,
  input  logic              din_valid,
  output logic              pgm_mode,
  output logic              erase_mode,
  output logic              hv_en,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);

  function automatic longint to_cyc(longint ns);
    longint c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic longint maxl(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

  localparam longint C_SU    = to_cyc(T_SU_NS);
  localparam longint C_HVD   = to_cyc(T_HVD_NS);
  localparam longint C_BYTE  = to_cyc(T_BYTE_NS);
  localparam longint C_HOLDP = to_cyc(T_HOLDP_NS);
  localparam longint C_ER    = to_cyc(T_ER_NS);
  localparam longint C_HOLDE = to_cyc(T_HOLDE_NS);
  localparam longint C_REC   = to_cyc(T_REC_NS);
  localparam longint C_BUD   = to_cyc(BUDGET_NS);
  localparam int     ROW_BYTES = 2 ** ROW_W;
  localparam int     NBYTES    = 2 ** ADDR_W;
  localparam int     NROWS     = 2 ** (ADDR_W - ROW_W);
  localparam longint C_MAX   = maxl(maxl(maxl(C_SU, C_HVD), maxl(C_BYTE, C_HOLDP)),
                                    maxl(maxl(C_ER, C_HOLDE), C_REC));
  localparam int     CW      = $clog2(C_MAX + 1);
  localparam longint EST_MAX = C_HVD + longint'(ROW_BYTES) * C_BYTE + C_HOLDP;
  localparam int     AW      = $clog2(C_BUD + EST_MAX + 1) + 1;
  localparam logic [AW-1:0] ACC_SAT = '1;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_HVD, S_WAITD, S_BYTE, S_ERASE, S_HOLD, S_REC
  } st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic              is_prog, aborted;
  logic [ADDR_W-1:0] next_addr;
  logic [ROW_W:0]    left;
  logic [ADDR_W-ROW_W-1:0] prow;
  logic [1:0]        wc  [NBYTES];
  logic [AW-1:0]     acc [NROWS];
  logic              done_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  wire abort_cmd = cmd_valid && (cmd_op == 2'd3);
  wire [ROW_W-1:0]        c_off = cmd_addr[ROW_W-1:0];
  wire [ADDR_W-ROW_W-1:0] c_row = cmd_addr[ADDR_W-1:ROW_W];
  wire [CW-1:0] hold_ld = is_prog ? CW'(C_HOLDP - 1) : CW'(C_HOLDE - 1);

  logic wc_bad, range_bad, bud_bad;

  always_comb begin
    wc_bad = 1'b0;
    for (int i = 0; i < ROW_BYTES; i++)
      if (i >= int'(c_off) && i < int'(c_off) + int'(cmd_count) &&
          wc[ADDR_W'(int'(c_row) * ROW_BYTES + i)] == 2'd2)
        wc_bad = 1'b1;
  end

  assign range_bad = (cmd_count == '0) || (int'(c_off) + int'(cmd_count) > ROW_BYTES);
  assign bud_bad   = (longint'(acc[c_row]) + C_HVD + longint'(cmd_count) * C_BYTE + C_HOLDP) > C_BUD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      is_prog   <= 1'b0;
      aborted   <= 1'b0;
      next_addr <= '0;
      left      <= '0;
      prow      <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      for (int i = 0; i < NBYTES; i++) wc[i] <= '0;
      for (int r = 0; r < NROWS; r++) acc[r] <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (hv_en && is_prog && acc[prow] != ACC_SAT) acc[prow] <= acc[prow] + 1'b1;
      case (st)
        S_IDLE: begin
          if (cmd_valid && cmd_op == 2'd1) begin
            if (range_bad || wc_bad || bud_bad) err_q <= 1'b1;
            else begin
              st        <= S_SETUP;
              cnt       <= CW'(C_SU - 1);
              is_prog   <= 1'b1;
              aborted   <= 1'b0;
              next_addr <= cmd_addr;
              left      <= cmd_count;
              prow      <= c_row;
            end
          end else if (cmd_valid && cmd_op == 2'd2) begin
            st      <= S_SETUP;
            cnt     <= CW'(C_SU - 1);
            is_prog <= 1'b0;
            aborted <= 1'b0;
          end
        end
        S_SETUP: begin
          if (abort_cmd) begin
            st <= S_REC; cnt <= CW'(C_REC - 1); aborted <= 1'b1;
          end else if (cnt == '0) begin
            st  <= is_prog ? S_HVD : S_ERASE;
            cnt <= is_prog ? CW'(C_HVD - 1) : CW'(C_ER - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_HVD: begin
          if (abort_cmd) begin
            st <= S_HOLD; cnt <= hold_ld; aborted <= 1'b1;
          end else if (cnt == '0) st <= S_WAITD;
          else cnt <= cnt - 1'b1;
        end
        S_WAITD: begin
          if (abort_cmd) begin
            st <= S_HOLD; cnt <= hold_ld; aborted <= 1'b1;
          end else if (din_valid) begin
            st            <= S_BYTE;
            cnt           <= CW'(C_BYTE - 1);
            addr_q        <= next_addr;
            data_q        <= din;
            wc[next_addr] <= wc[next_addr] + 2'd1;
            next_addr     <= next_addr + 1'b1;
            left          <= left - 1'b1;
          end
        end
        S_BYTE: begin
          if (abort_cmd) begin
            st <= S_HOLD; cnt <= hold_ld; aborted <= 1'b1;
          end else if (cnt == '0) begin
            if (left == '0) begin st <= S_HOLD; cnt <= hold_ld; end
            else st <= S_WAITD;
          end else cnt <= cnt - 1'b1;
        end
        S_ERASE: begin
          if (abort_cmd) begin
            st <= S_HOLD; cnt <= hold_ld; aborted <= 1'b1;
          end else if (cnt == '0) begin
            st <= S_HOLD; cnt <= hold_ld;
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (cnt == '0) begin st <= S_REC; cnt <= CW'(C_REC - 1); end
          else cnt <= cnt - 1'b1;
        end
        default: begin
          if (cnt == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            if (!is_prog && !aborted) begin
              for (int i = 0; i < NBYTES; i++) wc[i] <= '0;
              for (int r = 0; r < NROWS; r++) acc[r] <= '0;
            end
          end else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign pgm_mode   = is_prog && (st == S_SETUP || st == S_HVD || st == S_WAITD || st == S_BYTE);
  assign erase_mode = !is_prog && (st == S_SETUP || st == S_ERASE);
  assign hv_en      = (st == S_HVD) || (st == S_WAITD) || (st == S_BYTE) ||
                      (st == S_ERASE) || (st == S_HOLD);
  assign arr_wr     = (st == S_BYTE);
  assign arr_addr   = addr_q;
  assign arr_data   = data_q;
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign err        = err_q;

  a_r2_hv_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_en) |-> $past(pgm_mode || erase_mode) && (pgm_mode || erase_mode));

  a_r12_mode_off_before_hv: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_en) |-> !pgm_mode && !erase_mode && $past(!pgm_mode && !erase_mode));

  a_r3_write_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> hv_en && pgm_mode);

  a_r7_done_after_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !hv_en && $past(!hv_en));

  a_r6_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_mode && erase_mode));

  a_r10_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !hv_en);

endmodule

// File: tb/tb_flash_seq.sv
module tb_flash_seq;
  localparam int     ADDR_W = 6;
  localparam int     ROW_W  = 3;
  localparam longint MHZ    = 125;
  localparam longint SU_NS = 40, HVD_NS = 80, BYTE_NS = 160, HOLDP_NS = 40;
  localparam longint ER_NS = 4000, HOLDE_NS = 800, REC_NS = 10, BUD_NS = 1600;

  // R1: cycle counts derived independently from the requirement formula
  function automatic int cyc(longint ns);
    longint c;
    c = (ns * MHZ + 999) / 1000;
    return (c < 1) ? 1 : int'(c);
  endfunction
  localparam int K_SU = cyc(SU_NS), K_HVD = cyc(HVD_NS), K_BYTE = cyc(BYTE_NS);
  localparam int K_HOLDP = cyc(HOLDP_NS), K_ER = cyc(ER_NS), K_HOLDE = cyc(HOLDE_NS);
  localparam int K_REC = cyc(REC_NS), K_BUD = cyc(BUD_NS);

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [ADDR_W-1:0] cmd_addr = 0;
  logic [ROW_W:0] cmd_count = 0;
  logic [7:0] din = 0;
  logic din_valid = 0;
  logic pgm_mode, erase_mode, hv_en, arr_wr, busy, done, err;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0] arr_data;

  flash_seq #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .CLK_MHZ(MHZ),
    .T_SU_NS(SU_NS), .T_HVD_NS(HVD_NS), .T_BYTE_NS(BYTE_NS), .T_HOLDP_NS(HOLDP_NS),
    .T_ER_NS(ER_NS), .T_HOLDE_NS(HOLDE_NS), .T_REC_NS(REC_NS), .BUDGET_NS(BUD_NS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_count(cmd_count), .din(din), .din_valid(din_valid),
    .pgm_mode(pgm_mode), .erase_mode(erase_mode), .hv_en(hv_en), .arr_wr(arr_wr),
    .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy), .done(done), .err(err));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit gap_en = 0, finished = 0;

  // Behavioural reference: phase names and remaining-time integers
  string ph = "idle";
  int    rem = 0;
  bit    m_prog = 0, m_abt = 0;
  int    m_next = 0, m_left = 0, m_row = 0, m_bytes = 0;
  int    wcm [64];
  int    accm [8];
  bit    e_pgm = 0, e_er = 0, e_hv = 0, e_wr = 0, e_busy = 0, e_done = 0, e_err = 0;
  int    e_addr = 0, e_data = 0;

  function automatic bit refused(int a, int n);
    int off = a % 8, row = a / 8;
    if (n == 0 || off + n > 8) return 1;
    for (int i = off; i < off + n; i++) if (wcm[row*8+i] >= 2) return 1;
    if (accm[row] + K_HVD + n*K_BYTE + K_HOLDP > K_BUD) return 1;
    return 0;
  endfunction

  task automatic enter(string p, int len);
    ph = p; rem = len;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) wcm[i] = 0;
    for (int r = 0; r < 8; r++) accm[r] = 0;
  end

  always @(posedge clk) if (rst_n) begin
    bit ab, adv;
    ab = cmd_valid && cmd_op == 2'd3;
    if (e_hv && m_prog) accm[m_row]++;
    e_done = 0; e_err = 0;
    adv = (rem <= 1);
    if (ph == "idle") begin
      if (cmd_valid && cmd_op == 2'd1) begin
        if (refused(int'(cmd_addr), int'(cmd_count))) e_err = 1;
        else begin
          m_prog = 1; m_abt = 0; m_next = int'(cmd_addr); m_left = int'(cmd_count);
          m_row = int'(cmd_addr) / 8; enter("setup", K_SU);
        end
      end else if (cmd_valid && cmd_op == 2'd2) begin
        m_prog = 0; m_abt = 0; enter("setup", K_SU);
      end
    end else if (ph == "setup") begin
      if (ab) begin m_abt = 1; enter("rec", K_REC); end
      else if (adv) enter(m_prog ? "hvd" : "erase", m_prog ? K_HVD : K_ER);
      else rem--;
    end else if (ph == "hvd" || ph == "waitd" || ph == "byte" || ph == "erase") begin
      if (ab) begin m_abt = 1; enter("hold", m_prog ? K_HOLDP : K_HOLDE); end
      else if (ph == "waitd") begin
        if (din_valid) begin
          e_addr = m_next; e_data = int'(din); wcm[m_next]++; m_next++; m_left--;
          m_bytes++; enter("byte", K_BYTE);
        end
      end else if (adv) begin
        if (ph == "hvd") enter("waitd", 0);
        else if (ph == "byte" && m_left > 0) enter("waitd", 0);
        else enter("hold", m_prog ? K_HOLDP : K_HOLDE);
      end else rem--;
    end else if (ph == "hold") begin
      if (adv) enter("rec", K_REC); else rem--;
    end else begin
      if (adv) begin
        ph = "idle"; e_done = 1;
        if (!m_prog && !m_abt) begin   // R13
          for (int i = 0; i < 64; i++) wcm[i] = 0;
          for (int r = 0; r < 8; r++) accm[r] = 0;
        end
      end else rem--;
    end
    e_pgm  = m_prog && (ph == "setup" || ph == "hvd" || ph == "waitd" || ph == "byte");
    e_er   = !m_prog && (ph == "setup" || ph == "erase");
    e_hv   = (ph == "hvd" || ph == "waitd" || ph == "byte" || ph == "erase" || ph == "hold");
    e_wr   = (ph == "byte");
    e_busy = (ph != "idle");
  end

  task automatic cmp(string tag, string nm, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, nm, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!finished) begin
      cmp("R2", "pgm_mode", int'(pgm_mode), int'(e_pgm));
      cmp("R6", "erase_mode", int'(erase_mode), int'(e_er));
      cmp("R5", "hv_en", int'(hv_en), int'(e_hv));
      cmp("R3", "arr_wr", int'(arr_wr), int'(e_wr));
      cmp("R4", "arr_addr", int'(arr_addr), e_addr);
      cmp("R4", "arr_data", int'(arr_data), e_data);
      cmp("R11", "busy", int'(busy), int'(e_busy));
      cmp("R7", "done", int'(done), int'(e_done));
      cmp("R8", "err", int'(err), int'(e_err));
    end
    din_valid <= gap_en ? (cycles % 3 == 0) : 1'b1;
    din <= 8'(8'h5A + m_bytes * 37);
    if (cycles > 150000 && !finished) begin
      mismatched++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic send(logic [1:0] op, int a, int n);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = ADDR_W'(a); cmd_count = (ROW_W+1)'(n);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic expect_err(string tag, int a, int n);
    send(2'd1, a, n);
    compared++;
    if (err !== 1'b1 || busy !== 1'b0) begin
      mismatched++;
      $display("FAIL %s refusal: actual err=%0b busy=%0b expected err=1 busy=0", tag, err, busy);
    end
  endtask

  task automatic expect_start(string tag, logic [1:0] op, int a, int n);
    send(op, a, n);
    compared++;
    if (busy !== 1'b1) begin
      mismatched++;
      $display("FAIL %s start: actual busy=%0b expected busy=1", tag, busy);
    end
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (e_busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compared++;  // reset state
    if (busy || hv_en || pgm_mode || erase_mode || arr_wr || done || err) begin
      mismatched++;
      $display("FAIL R7 reset: actual outputs active expected all low");
    end
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R2 R3 R4 R5: three bytes in row 0
    expect_start("R2", 2'd1, 0, 3); wait_idle();
    // R7: next command in the done cycle; second write to byte 0
    expect_start("R7", 2'd1, 0, 1); wait_idle();
    expect_err("R9", 0, 1);
    expect_err("R10", 6, 3);
    expect_err("R10", 8, 0);
    // R4 with gaps in din_valid; R11 commands ignored while busy
    gap_en = 1;
    send(2'd1, 10, 2);
    repeat (4) @(negedge clk);
    send(2'd2, 0, 0);
    send(2'd1, 40, 1);
    wait_idle();
    gap_en = 0;
    // R8: full row then over budget
    expect_start("R8", 2'd1, 16, 8); wait_idle();
    expect_err("R8", 23, 1);
    // R12: abort during write step
    send(2'd1, 24, 4);
    repeat (K_SU + K_HVD + 6) @(negedge clk);
    send(2'd3, 0, 0); wait_idle();
    // R12: abort during erase setup
    send(2'd2, 0, 0); @(negedge clk);
    send(2'd3, 0, 0); wait_idle();
    // R12 R13: abort during erase high voltage, nothing cleared
    send(2'd2, 0, 0);
    repeat (K_SU + 50) @(negedge clk);
    send(2'd3, 0, 0); wait_idle();
    expect_err("R13", 0, 1);
    // R6 R13: full erase then limits are cleared
    expect_start("R6", 2'd2, 0, 0); wait_idle();
    expect_start("R13", 2'd1, 0, 1); wait_idle();
    expect_start("R13", 2'd1, 16, 8); wait_idle();
    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule